// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is an eight-line general-purpose I/O controller reached through a byte-wide register port with a write strobe and a combinational read path. Every line has a direction bit and an output latch. Output pins are modelled as a value vector and an enable vector, so the pad ring can build the tri-state driver. Incoming pin levels pass through a two-flop synchroniser. Software can read the synchronised levels back at any time.

The upper four lines can also raise interrupts. For each of these lines the block detects rising and falling edges continuously and latches each kind into its own pending flag, whatever the current configuration. A two-bit trigger field per line then decides which of the two flags is shown in the status register. The shown flags are ORed together into one interrupt output for the host.

Writing a one to a status bit clears both hidden flags of that line in a single step. If an edge arrives in the same cycle as the clear, that edge is kept. Software can therefore clear a line and then pick a new trigger without losing an event.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset the direction register reads 0x0F, so lines 0 to 3 are outputs and lines 4 to 7 are inputs. After reset the output latch, the trigger configuration and the status all read zero, and the interrupt output is low.
- R2: The direction register is at offset 0. A bit value of 1 makes that line an output, and pin_oe follows a write in the next cycle. Any line may change direction at any time.
- R3: A write to offset 1 loads the output latch. pin_out carries the latch bit on lines whose direction bit is 1 and carries 0 on all other lines.
- R4: A read of offset 1 returns the pin levels after two synchronising flops. A pin change made before a clock edge shows in the read after the second edge, not after the first.
- R5: Only lines 4 to 7 can interrupt. Edges on lines 0 to 3 never set a status bit.
- R6: The trigger configuration register is at offset 3. Bits [2i+1:2i] hold the trigger of line 4+i: 00 = none, 01 = falling edge, 10 = rising edge, 11 = none. The register reads back as written.
- R7: Rising and falling edges are latched into separate pending flags even when the configuration does not select them. Selecting a trigger later shows an edge that was already latched.
- R8: The status register is at offset 4. Bit i shows the pending flag of line 4+i for the selected edge type, and shows 0 when the trigger is none.
- R9: Writing 1 to status bit i clears both the rising and the falling flag of line 4+i. Writing 0 to a bit leaves that bit unchanged.
- R10: The irq output is high exactly when at least one status bit reads 1.
- R11: An edge that is detected in the same cycle as a clear of its line stays pending.
- R12: Offsets 2, 5, 6 and 7 read as zero. Writes to these offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables |
| irq | output | 1 | Aggregated interrupt |

## Verification
The main sweep covers all four interrupt lines, all four trigger encodings and both edge polarities. It checks the status byte and irq against a value computed in the bench. This separates a wrong field position, a swapped polarity, and a wrong treatment of the 11 code. Separate sequences latch an edge while the trigger is off and select it afterwards. Other sequences pulse a line so that both flags are set and then clear it, which shows whether the clear covers the hidden flag too. A timed stimulus puts a new rising edge in the same cycle as a clear, and the bench expects the edge to survive. Further checks cover the two-cycle synchroniser latency, the masking of output values by the direction bits, edges on the non-interrupt lines, and the unused offsets.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   typedef enum logic [1:0] {
      TRIG_NONE = 2'b00,
      TRIG_FALL = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_OFF  = 2'b11
   } trig_e;

   localparam int OFS_DIR  = 0;
   localparam int OFS_DATA = 1;
   localparam int OFS_CFG  = 3;
   localparam int OFS_STAT = 4;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_edge_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= d_i;
   end

   generate
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_q[k-1];
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
   import gpio_edge_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level_i,
   input  logic       clr_i,
   input  logic [1:0] trig_i,
   output logic       vis_o
);
   logic prev_q, rise_q, fall_q;
   logic rise_ev, fall_ev;

   assign rise_ev = level_i & ~prev_q;
   assign fall_ev = ~level_i & prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         prev_q <= level_i;
         rise_q <= (rise_q & ~clr_i) | rise_ev;
         fall_q <= (fall_q & ~clr_i) | fall_ev;
      end
   end

   always_comb begin
      case (trig_e'(trig_i))
         TRIG_RISE: vis_o = rise_q;
         TRIG_FALL: vis_o = fall_q;
         default:   vis_o = 1'b0;
      endcase
   end

   // R9
   clr_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !rise_ev && !fall_ev) |=> (!rise_q && !fall_q));

   // R11
   rise_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_ev |=> rise_q);

   // R11
   fall_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_ev |=> fall_q);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int NUM_LINES     = 8,
   parameter int NUM_IRQ       = 4,
   parameter int DIR_OUT_LINES = 4,
   parameter int ADDR_W        = 3,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [NUM_LINES-1:0] reg_wdata,
   output logic [NUM_LINES-1:0] reg_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe,
   output logic                 irq
);
   localparam int IRQ_BASE = NUM_LINES - NUM_IRQ;
   localparam int CFG_W    = 2 * NUM_IRQ;
   localparam logic [NUM_LINES-1:0] DIR_RST =
      {NUM_LINES{1'b1}} >> (NUM_LINES - DIR_OUT_LINES);

   generate
      if (CFG_W > NUM_LINES) begin : g_bad_cfg
         $error("trigger fields do not fit one register");
      end
      if (DIR_OUT_LINES > NUM_LINES) begin : g_bad_dir
         $error("more reset outputs than lines");
      end
      if ((1 << ADDR_W) <= OFS_STAT) begin : g_bad_addr
         $error("address too narrow for register map");
      end
   endgenerate

   logic [NUM_LINES-1:0] dir_q, latch_q, lvl;
   logic [CFG_W-1:0]     cfg_q;
   logic [NUM_IRQ-1:0]   vis, clr;
   logic                 wr_dir, wr_data, wr_cfg, wr_stat;

   assign wr_dir  = reg_wr && (reg_addr == ADDR_W'(OFS_DIR));
   assign wr_data = reg_wr && (reg_addr == ADDR_W'(OFS_DATA));
   assign wr_cfg  = reg_wr && (reg_addr == ADDR_W'(OFS_CFG));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= DIR_RST;
         latch_q <= '0;
         cfg_q   <= '0;
      end else begin
         if (wr_dir)  dir_q   <= reg_wdata;
         if (wr_data) latch_q <= reg_wdata;
         if (wr_cfg)  cfg_q   <= reg_wdata[CFG_W-1:0];
      end
   end

   gpio_edge_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (lvl)
   );

   assign clr = wr_stat ? reg_wdata[NUM_IRQ-1:0] : '0;

   generate
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
         gpio_edge_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (lvl[IRQ_BASE+i]),
            .clr_i   (clr[i]),
            .trig_i  (cfg_q[2*i +: 2]),
            .vis_o   (vis[i])
         );
      end
   endgenerate

   always_comb begin
      case (reg_addr)
         ADDR_W'(OFS_DIR):  reg_rdata = dir_q;
         ADDR_W'(OFS_DATA): reg_rdata = lvl;
         ADDR_W'(OFS_CFG):  reg_rdata = NUM_LINES'(cfg_q);
         ADDR_W'(OFS_STAT): reg_rdata = NUM_LINES'(vis);
         default:           reg_rdata = '0;
      endcase
   end

   assign pin_out = latch_q & dir_q;
   assign pin_oe  = dir_q;
   assign irq     = |vis;

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (pin_oe == $past(reg_wdata)));

   // R3
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (pin_out == ($past(reg_wdata) & pin_oe)));

   // R6
   cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> (cfg_q == $past(reg_wdata[CFG_W-1:0])));
endmodule

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] pin_in = '0;
   logic [7:0] rdata, pin_out, pin_oe;
   logic       irq;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;
   logic [7:0] rv;

   always #10 clk = ~clk;

   gpio_edge_ctrl u_gpio_edge_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (addr),
      .reg_wr    (wr),
      .reg_wdata (wdata),
      .reg_rdata (rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      addr = a;
      wdata = d;
      wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd_reg(0, rv); check("R1 dir", rv, 8'h0F);
      rd_reg(1, rv); check("R1 data", rv, 8'h00);
      rd_reg(3, rv); check("R1 cfg", rv, 8'h00);
      rd_reg(4, rv); check("R1 status", rv, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);
      check("R1 oe", pin_oe, 8'h0F);
      check("R1 out", pin_out, 8'h00);

      // R2 direction change
      wr_reg(0, 8'hA5);
      check("R2 oe", pin_oe, 8'hA5);
      rd_reg(0, rv); check("R2 readback", rv, 8'hA5);

      // R3 latch masked by direction
      wr_reg(1, 8'hFF);
      check("R3 out all", pin_out, 8'hA5);
      wr_reg(1, 8'h3C);
      check("R3 out mix", pin_out, 8'h24);
      wr_reg(0, 8'h0F);
      check("R3 out redir", pin_out, 8'h0C);

      // R4 synchroniser latency
      pin_in = 8'h96;
      tick(1);
      rd_reg(1, rv); check("R4 one edge", rv, 8'h00);
      tick(1);
      rd_reg(1, rv); check("R4 two edges", rv, 8'h96);
      pin_in = 8'h00;
      tick(4);
      wr_reg(4, 8'h0F);

      // R12 unused offsets
      for (int a = 2; a < 8; a++) begin
         if (a == 2 || a > 4) begin
            rd_reg(a[2:0], rv); check("R12 unused read", rv, 8'h00);
         end
      end
      wr_reg(2, 8'hFF);
      wr_reg(6, 8'hFF);
      rd_reg(0, rv); check("R12 dir kept", rv, 8'h0F);
      rd_reg(3, rv); check("R12 cfg kept", rv, 8'h00);
      rd_reg(4, rv); check("R12 status kept", rv, 8'h00);

      // R5 low lines never interrupt
      wr_reg(3, 8'hAA);
      pin_in = 8'h0F;
      tick(4);
      rd_reg(4, rv); check("R5 rise low lines", rv, 8'h00);
      pin_in = 8'h00;
      wr_reg(3, 8'h55);
      tick(4);
      rd_reg(4, rv); check("R5 fall low lines", rv, 8'h00);
      check("R5 irq", {7'd0, irq}, 8'h00);
      wr_reg(3, 8'h00);

      // R6 R8 R10 sweep: line x trigger code x polarity
      for (int i = 0; i < 4; i++) begin
         for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 2; e++) begin
               logic [7:0] bitm, cfgv, exp;
               bitm = 8'h10 << i;
               cfgv = 8'(c << (2 * i));
               pin_in = (e == 1) ? bitm : 8'h00;
               tick(4);
               wr_reg(4, 8'h0F);
               wr_reg(3, cfgv);
               rd_reg(3, rv); check("R6 cfg readback", rv, cfgv);
               pin_in = pin_in ^ bitm;
               tick(4);
               exp = ((c == 2 && e == 0) || (c == 1 && e == 1)) ? 8'(1 << i) : 8'h00;
               rd_reg(4, rv); check("R8 status sweep", rv, exp);
               check("R10 irq sweep", {7'd0, irq}, {7'd0, (exp != 0)});
               pin_in = 8'h00;
               tick(4);
               wr_reg(3, 8'h00);
               wr_reg(4, 8'h0F);
            end
         end
      end

      // R7 latched while unselected
      pin_in = 8'h20;
      tick(4);
      pin_in = 8'h00;
      tick(4);
      rd_reg(4, rv); check("R7 hidden", rv, 8'h00);
      wr_reg(3, 8'h08);
      rd_reg(4, rv); check("R7 rise shown", rv, 8'h02);
      wr_reg(3, 8'h04);
      rd_reg(4, rv); check("R7 fall shown", rv, 8'h02);
      check("R10 irq on", {7'd0, irq}, 8'h01);

      // R9 clear both flags
      wr_reg(4, 8'h00);
      rd_reg(4, rv); check("R9 write zero", rv, 8'h02);
      wr_reg(4, 8'h02);
      rd_reg(4, rv); check("R9 fall cleared", rv, 8'h00);
      wr_reg(3, 8'h08);
      rd_reg(4, rv); check("R9 rise cleared", rv, 8'h00);
      check("R10 irq off", {7'd0, irq}, 8'h00);

      // R11 edge in the clearing cycle survives
      wr_reg(3, 8'h02);
      pin_in = 8'h10;
      tick(4);
      pin_in = 8'h00;
      tick(4);
      rd_reg(4, rv); check("R11 pre", rv, 8'h01);
      pin_in = 8'h10;
      tick(2);
      wr_reg(4, 8'h01);
      rd_reg(4, rv); check("R11 edge kept", rv, 8'h01);
      wr_reg(3, 8'h01);
      rd_reg(4, rv); check("R11 old fall cleared", rv, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule